// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits each and returns their full `2*WIDTH`-bit signed product. It works iteratively and retires two multiplier bits on every clock. In each iteration it inspects three multiplier bits: the two bits now at the bottom of the shifting register, plus the bit that was shifted out just below them. From those three bits it picks one of five partial products (zero, plus or minus the multiplicand, plus or minus twice the multiplicand). It adds that choice into the upper half of a wide accumulator and then shifts the whole accumulator right by two places, extending the sign.

A client drives both operands and raises `start` for one cycle while the block is idle. Exactly `WIDTH/2` clock edges after the edge that accepted the request, `done` is high for one cycle and `product` holds the result. The result stays on `product` until the block accepts another request. A `start` that arrives while an operation is running is dropped.

Top module: `booth4_mult`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge clears `product` to zero and `done` to 0. This also applies when an operation is in progress, and that aborted operation never raises `done`.
- R2: For any pair of `WIDTH`-bit signed operands, `product` equals their exact signed product as a `2*WIDTH`-bit two's-complement value in the cycle in which `done` is high.
- R3: If `start` is accepted at clock edge E, `done` is 0 after edges E+1 through E+WIDTH/2-1. It is 1 for exactly the one cycle after edge E+WIDTH/2 and 0 again after the next edge.
- R4: A `start` seen while an operation is running is ignored. The running operation keeps its own operands and its own completion time.
- R5: While idle with `start` low, `product` stays unchanged, whatever the operand inputs do.
- R6: Each three-bit group, written as {upper bit, lower bit, bit to the right}, selects a partial product: 000 and 111 select 0; 001 and 010 select +M; 011 selects +2M; 100 selects -2M; 101 and 110 select -M. The bit to the right of the multiplier's least significant bit is 0 in the first iteration.
- R7: The most negative operand values, including the most negative value times itself and times the most positive value, give the exact product without overflow.
- R8: A `start` given in the cycle in which `done` is high is accepted, and the new operation completes WIDTH/2 edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a multiplication; taken only while idle |
| multiplicand | input | WIDTH | Signed multiplicand M, sampled at the accepting edge |
| multiplier | input | WIDTH | Signed multiplier, sampled at the accepting edge |
| product | output | 2*WIDTH | Signed product; valid when `done` is high and held afterwards |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the assertions check four things: the value at completion against a product of the operands captured at acceptance, the exact spacing between acceptance and `done`, the single-cycle width of `done`, and the holding of `product` while idle. These per-cycle properties cannot show that each recoding group is reached, that the extreme operand values pass through the widened adder, or what happens when a start is dropped mid-run, when requests run back-to-back, or when reset strikes mid-operation. The bench's chosen vectors and directed scenarios show those.

// File: rtl/booth4_pkg.sv
// Shared types for the radix-4 Booth multiplier.
// Assumes nothing beyond a synthesizable enum encoding.
package booth4_pkg;

    // Partial-product choice made by one recoded group.
    typedef enum logic [2:0] {
        PP_ZERO = 3'd0,
        PP_POS1 = 3'd1,
        PP_POS2 = 3'd2,
        PP_NEG1 = 3'd3,
        PP_NEG2 = 3'd4
    } pp_sel_e;

endpackage

// File: rtl/booth4_recode.sv
// Radix-4 recoder: maps a {hi, lo, right} bit triple onto one of five
// partial-product choices. Purely combinational; no assumptions.
module booth4_recode
    import booth4_pkg::*;
(
    input  logic [2:0] grp,
    output pp_sel_e    sel
);

    // Table lookup of the overlapping triple.
    always_comb begin
        case (grp)
            3'b001, 3'b010: sel = PP_POS1;
            3'b011:         sel = PP_POS2;
            3'b100:         sel = PP_NEG2;
            3'b101, 3'b110: sel = PP_NEG1;
            default:        sel = PP_ZERO;
        endcase
    end

endmodule

// File: rtl/booth4_ppgen.sv
// Partial-product generator: produces 0, +-M or +-2M, sign-extended to
// W+2 bits so that the accumulator add cannot overflow.
// Assumes mcand is a signed two's-complement value.
module booth4_ppgen
    import booth4_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] mcand,
    input  pp_sel_e      sel,
    output logic [W+1:0] pp
);

    localparam int PW = W + 2;

    logic [PW-1:0] single_m;
    logic [PW-1:0] double_m;

    // Sign-extended M and M shifted left by one.
    always_comb begin
        single_m = {{2{mcand[W-1]}}, mcand};
        double_m = {mcand[W-1], mcand, 1'b0};
    end

    // Select and, where needed, negate the multiple.
    always_comb begin
        case (sel)
            PP_POS1: pp = single_m;
            PP_POS2: pp = double_m;
            PP_NEG1: pp = ~single_m + PW'(1);
            PP_NEG2: pp = ~double_m + PW'(1);
            default: pp = '0;
        endcase
    end

endmodule

// File: rtl/booth4_ctrl.sv
// Sequencer: accepts a request while idle, keeps the block busy for
// ITERS cycles, then pulses done. Requests while busy are dropped.
// Assumes ITERS >= 1.
module booth4_ctrl #(
    parameter int ITERS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic busy,
    output logic done
);

    localparam int CW = (ITERS > 1) ? $clog2(ITERS) : 1;
    localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

    logic [CW-1:0] iter_q;

    // A request counts only while idle.
    assign accept = start & ~busy;

    // Iteration counter, busy flag and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iter_q <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                iter_q <= '0;
                busy   <= 1'b1;
            end else if (busy) begin
                iter_q <= iter_q + CW'(1);
                if (iter_q == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/booth4_dp.sv
// Datapath: wide accumulator {hi, lo, right-bit}. On load it captures the
// operands; on each step it adds the recoded partial product into hi and
// shifts the whole accumulator right by two with sign extension.
// Assumes W is even.
module booth4_dp
    import booth4_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    output logic [2*W-1:0] product
);

    localparam int PW = W + 2;

    logic [PW-1:0] acc_hi;
    logic [W-1:0]  acc_lo;
    logic          right_q;
    logic [W-1:0]  mcand_q;

    pp_sel_e       sel;
    logic [PW-1:0] pp;
    logic [PW-1:0] sum;

    booth4_recode u_recode (
        .grp ({acc_lo[1:0], right_q}),
        .sel (sel)
    );

    booth4_ppgen #(.W(W)) u_ppgen (
        .mcand (mcand_q),
        .sel   (sel),
        .pp    (pp)
    );

    // Add the selected multiple into the upper half.
    assign sum = acc_hi + pp;

    // Load operands or perform one add-and-shift iteration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_hi  <= '0;
            acc_lo  <= '0;
            right_q <= 1'b0;
            mcand_q <= '0;
        end else if (load) begin
            acc_hi  <= '0;
            acc_lo  <= mplier_in;
            right_q <= 1'b0;
            mcand_q <= mcand_in;
        end else if (step) begin
            acc_hi  <= {{2{sum[PW-1]}}, sum[PW-1:2]};
            acc_lo  <= {sum[1:0], acc_lo[W-1:2]};
            right_q <= acc_lo[1];
        end
    end

    assign product = {acc_hi[W-1:0], acc_lo};

endmodule

// File: rtl/booth4_mult.sv
// Radix-4 Booth sequential signed multiplier, WIDTH/2 cycles per product.
// Assumes WIDTH is even and at least 2; operands are two's complement.
module booth4_mult #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH-1:0]   multiplicand,
    input  logic [WIDTH-1:0]   multiplier,
    output logic [2*WIDTH-1:0] product,
    output logic               done
);

    localparam int ITERS = WIDTH / 2;

    logic accept;
    logic busy;

    booth4_ctrl #(.ITERS(ITERS)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .accept (accept),
        .busy   (busy),
        .done   (done)
    );

    booth4_dp #(.W(WIDTH)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .step      (busy),
        .mcand_in  (multiplicand),
        .mplier_in (multiplier),
        .product   (product)
    );

endmodule

// File: rtl/booth4_mult_chk.sv
// Checker for booth4_mult: captures operands at acceptance, counts busy
// cycles, and checks result, timing and hold behaviour.
module booth4_mult_chk #(
    parameter int WIDTH = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic [WIDTH-1:0]   multiplicand,
    input logic [WIDTH-1:0]   multiplier,
    input logic [2*WIDTH-1:0] product,
    input logic               done
);

    localparam int PWID = 2 * WIDTH;
    localparam logic [15:0] ITERS16 = 16'(WIDTH / 2);

    logic [PWID-1:0] exp_q;
    logic [15:0]     cyc_q;

    // Reference product and elapsed busy cycles per accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q <= '0;
            cyc_q <= '0;
        end else if (start && !busy) begin
            exp_q <= PWID'($signed(multiplicand)) * PWID'($signed(multiplier));
            cyc_q <= '0;
        end else if (busy) begin
            cyc_q <= cyc_q + 16'd1;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (product == '0 && !done));

    // R2
    product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> product == exp_q);

    // R3
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cyc_q == ITERS16);

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));

endmodule

bind booth4_mult booth4_mult_chk #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .busy         (busy),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .product      (product),
    .done         (done)
);

// File: tb/booth4_mult_bench.sv
module booth4_mult_bench;

    localparam int W     = 8;
    localparam int PW    = 2 * W;
    localparam int ITERS = W / 2;
    localparam int NVEC  = 12;

    // {multiplicand, multiplier}; together the multipliers reach all eight groups (R6)
    localparam logic [15:0] VEC [NVEC] = '{
        16'h8080, 16'h807F, 16'h7F7F, 16'hFFFF,
        16'h005A, 16'h0306, 16'h02FD, 16'h55AA,
        16'h7F80, 16'hC33C, 16'h2BE7, 16'hD62B
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  multiplicand = '0;
    logic [W-1:0]  multiplier = '0;
    logic [PW-1:0] product;
    logic          done;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    booth4_mult #(.WIDTH(W)) u_booth4_mult (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .multiplicand (multiplicand),
        .multiplier   (multiplier),
        .product      (product),
        .done         (done)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles == 20000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        return PW'($signed(a)) * PW'($signed(b));
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Called just after a negedge; start is sampled at the next posedge.
    task automatic start_op(input logic [W-1:0] a, input logic [W-1:0] b);
        multiplicand = a;
        multiplier   = b;
        start        = 1'b1;
        @(negedge clk);
        start        = 1'b0;
    endtask

    // Walks WIDTH/2 edges after acceptance, checking done timing and result.
    task automatic await_done(input logic [PW-1:0] exp, input string req);
        for (int k = 1; k <= ITERS; k++) begin
            @(negedge clk);
            check(done == (k == ITERS), "R3", "done timing", 64'(done), 64'(k == ITERS));
        end
        check(product == exp, req, "product", 64'(product), 64'(exp));
    endtask

    initial begin
        logic [PW-1:0] e;

        // R1 reset state
        repeat (3) @(negedge clk);
        check(product == '0, "R1", "product after reset", 64'(product), 64'(0));
        check(done == 1'b0, "R1", "done after reset", 64'(done), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R6 R7 vector table
        for (int i = 0; i < NVEC; i++) begin
            e = ref_mul(VEC[i][15:8], VEC[i][7:0]);
            start_op(VEC[i][15:8], VEC[i][7:0]);
            await_done(e, "R2/R6/R7");
            @(negedge clk);
            check(done == 1'b0, "R3", "done drops", 64'(done), 64'(0));
            check(product == e, "R5", "product held", 64'(product), 64'(e));
        end

        // R4 start during busy is ignored
        start_op(8'h03, 8'h05);
        multiplicand = 8'h7F;
        multiplier   = 8'h7F;
        start        = 1'b1;
        @(negedge clk);
        start        = 1'b0;
        for (int k = 2; k <= ITERS; k++) begin
            @(negedge clk);
            check(done == (k == ITERS), "R4", "done timing kept", 64'(done), 64'(k == ITERS));
        end
        check(product == 16'd15, "R4", "product of first request", 64'(product), 64'd15);
        @(negedge clk);
        check(done == 1'b0, "R4", "no second completion", 64'(done), 64'(0));

        // R8 back-to-back: start in the done cycle
        start_op(8'hF9, 8'h06);
        await_done(ref_mul(8'hF9, 8'h06), "R2");
        start_op(8'h80, 8'hFF);
        await_done(ref_mul(8'h80, 8'hFF), "R8");

        // R5 idle hold with changing inputs
        e = ref_mul(8'h80, 8'hFF);
        for (int k = 0; k < 5; k++) begin
            multiplicand = 8'(k * 37 + 1);
            multiplier   = 8'(k * 91 + 5);
            @(negedge clk);
            check(product == e, "R5", "idle hold", 64'(product), 64'(e));
        end

        // R1 reset during an operation
        start_op(8'h55, 8'h55);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(product == '0, "R1", "product after mid-op reset", 64'(product), 64'(0));
        check(done == 1'b0, "R1", "done after mid-op reset", 64'(done), 64'(0));
        for (int k = 0; k < ITERS + 2; k++) begin
            @(negedge clk);
            check(done == 1'b0, "R1", "aborted op silent", 64'(done), 64'(0));
        end

        // R2 after reset recovery
        start_op(8'hAB, 8'hCD);
        await_done(ref_mul(8'hAB, 8'hCD), "R2");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule